// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough

This block gathers 32 level-sensitive interrupt sources in front of a primary vectored controller. Each cycle it captures the source levels into a raw-level register. An enable mask selects which captured levels count toward one combined request, and that request is driven on output line 31. Sources 21 to 30 can also be routed one by one straight to their own output lines, so the primary controller can see and prioritise them individually.

Software reaches the block over a plain 32-bit register bus. The bus has separate read and write strobes and a 12-bit byte address, which gives a 4 KB window decoded by 32-bit word. Writes take effect at the next clock edge. Read data is valid in the same cycle as the read strobe. The enable mask and the passthrough enable are written only through dedicated set and clear offsets, so no read-modify-write is ever needed.

Top module: `sec_irq_ctrl`

## Requirements
- R1: The raw-level register captures `irq_in` at every clock edge, so a change on an input is visible one cycle later.
- R2: `irq_out[31]` is high exactly when at least one bit of (raw level AND enable mask) is set.
- R3: With `bus_rd` high, word offset 0 (address bits [11:2]) reads raw level AND enable mask, offset 1 reads the raw level and offset 2 reads the enable mask. With `bus_rd` low, `bus_rdata` is zero.
- R4: A write to word offset 2 ORs the write data into the enable mask. A write to word offset 3 clears every mask bit that is 1 in the write data.
- R5: A write of any nonzero value to word offset 4 sets mask bit 0, and a nonzero write to offset 5 clears it. A zero write to either offset has no effect. Reading offset 4 returns raw-level bit 0 in bit 0 and zeros in bits 31:1.
- R6: A write to word offset 8 ORs (write data AND 0x7FE00000) into the passthrough enable, so only bits 21..30 can ever be set. Reading offset 8 returns the passthrough enable.
- R7: A write to word offset 9 clears every passthrough enable bit that is 1 in the write data.
- R8: For lines 21..30, `irq_out[i]` equals raw-level bit i while passthrough enable bit i is set, and is low otherwise. Lines 0..20 are always low, and line 31 never carries a passthrough.
- R9: Reads of any word offset other than 0, 1, 2, 4 and 8 return zero. Writes to any word offset other than 2, 3, 4, 5, 8 and 9 change nothing. Address bits [1:0] are ignored.
- R10: While reset is active, and directly after it, the raw level, the enable mask and the passthrough enable are zero and every output line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| bus_addr | input | 12 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as `bus_rd` |
| irq_out | output | 32 | Lines to the primary controller: 31 combined, 21..30 passthrough |

## Verification
The properties assume that the bus never carries unknown values while a strobe is high, and that `irq_in` is a plain level that may change only once per cycle. The bench keeps within these assumptions by changing sources, addresses and strobes only on the falling clock edge and by releasing each strobe before the next access. Under these conditions the stored state at any cycle follows only from the previous cycle's write and input levels, so the properties can compare one cycle with the next. The bench walks one active source across all 32 lines and writes to every one of the 1024 word offsets.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;

    parameter int unsigned SIC_W   = 32;
    parameter int unsigned ADDR_W  = 12;
    parameter int unsigned WOFF_W  = ADDR_W - 2;

    // Word offsets whose position the software interface depends on
    localparam logic [WOFF_W-1:0] OFF_STATUS  = WOFF_W'(0);
    localparam logic [WOFF_W-1:0] OFF_RAW     = WOFF_W'(1);
    localparam logic [WOFF_W-1:0] OFF_MASKSET = WOFF_W'(2);
    localparam logic [WOFF_W-1:0] OFF_MASKCLR = WOFF_W'(3);
    localparam logic [WOFF_W-1:0] OFF_SOFTSET = WOFF_W'(4);
    localparam logic [WOFF_W-1:0] OFF_SOFTCLR = WOFF_W'(5);
    localparam logic [WOFF_W-1:0] OFF_PTSET   = WOFF_W'(8);
    localparam logic [WOFF_W-1:0] OFF_PTCLR   = WOFF_W'(9);

    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_STATUS,
        SEL_RAW,
        SEL_MASK,
        SEL_SOFT,
        SEL_PT
    } rd_sel_e;

    typedef struct packed {
        logic mask_set;
        logic mask_clr;
        logic soft_set;
        logic soft_clr;
        logic pt_set;
        logic pt_clr;
    } wr_strobe_t;

    typedef struct packed {
        logic [SIC_W-1:0] level;
        logic [SIC_W-1:0] mask;
        logic [SIC_W-1:0] pt;
    } sic_state_t;

endpackage

// File: rtl/sec_irq_decode.sv
module sec_irq_decode
    import sec_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output wr_strobe_t        wstb,
    output rd_sel_e           rsel
);

    logic [WOFF_W-1:0] woff;
    logic [1:0]        unused_byte_lane;

    assign woff             = addr[ADDR_W-1:2];
    assign unused_byte_lane = addr[1:0];

    always_comb begin
        wstb = '0;
        if (wr) begin
            case (woff)
                OFF_MASKSET: wstb.mask_set = 1'b1;
                OFF_MASKCLR: wstb.mask_clr = 1'b1;
                OFF_SOFTSET: wstb.soft_set = 1'b1;
                OFF_SOFTCLR: wstb.soft_clr = 1'b1;
                OFF_PTSET:   wstb.pt_set   = 1'b1;
                OFF_PTCLR:   wstb.pt_clr   = 1'b1;
                default:     wstb          = '0;
            endcase
        end
    end

    always_comb begin
        rsel = SEL_ZERO;
        if (rd) begin
            case (woff)
                OFF_STATUS:  rsel = SEL_STATUS;
                OFF_RAW:     rsel = SEL_RAW;
                OFF_MASKSET: rsel = SEL_MASK;
                OFF_SOFTSET: rsel = SEL_SOFT;
                OFF_PTSET:   rsel = SEL_PT;
                default:     rsel = SEL_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/sec_irq_state.sv
module sec_irq_state
    import sec_irq_pkg::*;
#(
    parameter int unsigned PT_LO = 21,
    parameter int unsigned PT_HI = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIC_W-1:0] irq_in,
    input  wr_strobe_t       wstb,
    input  logic [SIC_W-1:0] wdata,
    output sic_state_t       st
);

    localparam logic [63:0] PT_SPAN =
        ((64'd1 << (PT_HI + 1)) - 64'd1) & ~((64'd1 << PT_LO) - 64'd1);
    localparam logic [SIC_W-1:0] PT_MASK = PT_SPAN[SIC_W-1:0];

    sic_state_t st_d, st_q;
    logic       wdata_nz;

    assign wdata_nz = |wdata;

    always_comb begin
        st_d       = st_q;
        st_d.level = irq_in;
        if (wstb.mask_set)             st_d.mask    = st_q.mask | wdata;
        if (wstb.mask_clr)             st_d.mask    = st_q.mask & ~wdata;
        if (wstb.soft_set && wdata_nz) st_d.mask[0] = 1'b1;
        if (wstb.soft_clr && wdata_nz) st_d.mask[0] = 1'b0;
        if (wstb.pt_set)               st_d.pt      = st_q.pt | (wdata & PT_MASK);
        if (wstb.pt_clr)               st_d.pt      = st_q.pt & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

endmodule

// File: rtl/sec_irq_route.sv
module sec_irq_route
    import sec_irq_pkg::*;
#(
    parameter int unsigned PT_LO    = 21,
    parameter int unsigned PT_HI    = 30,
    parameter int unsigned COMB_IDX = 31
) (
    input  sic_state_t       st,
    output logic [SIC_W-1:0] lines
);

    logic any_pending;

    assign any_pending = |(st.level & st.mask);

    for (genvar i = 0; i < SIC_W; i++) begin : g_line
        if (i == COMB_IDX) begin : g_comb
            assign lines[i] = any_pending;
        end else if (i >= PT_LO && i <= PT_HI) begin : g_pass
            assign lines[i] = st.level[i] & st.pt[i];
        end else begin : g_idle
            assign lines[i] = 1'b0;
        end
    end

endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
    import sec_irq_pkg::*;
#(
    parameter int unsigned PT_LO    = 21,
    parameter int unsigned PT_HI    = 30,
    parameter int unsigned COMB_IDX = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] irq_in,
    input  logic [11:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [31:0] irq_out
);

    wr_strobe_t       wstb;
    rd_sel_e          rsel;
    sic_state_t       st;
    logic [SIC_W-1:0] lvl_w, msk_w, pt_w;

    sec_irq_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .wstb (wstb),
        .rsel (rsel)
    );

    sec_irq_state #(.PT_LO(PT_LO), .PT_HI(PT_HI)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .wstb   (wstb),
        .wdata  (bus_wdata),
        .st     (st)
    );

    sec_irq_route #(.PT_LO(PT_LO), .PT_HI(PT_HI), .COMB_IDX(COMB_IDX)) u_route (
        .st    (st),
        .lines (irq_out)
    );

    assign lvl_w = st.level;
    assign msk_w = st.mask;
    assign pt_w  = st.pt;

    always_comb begin
        case (rsel)
            SEL_STATUS: bus_rdata = lvl_w & msk_w;
            SEL_RAW:    bus_rdata = lvl_w;
            SEL_MASK:   bus_rdata = msk_w;
            SEL_SOFT:   bus_rdata = {{(SIC_W-1){1'b0}}, lvl_w[0]};
            SEL_PT:     bus_rdata = pt_w;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sec_irq_ctrl_chk.sv
module sec_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] irq_in,
    input logic [11:0] bus_addr,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic [31:0] irq_out,
    input logic [31:0] lvl,
    input logic [31:0] msk,
    input logic [31:0] pt
);

    logic [9:0] woff;
    logic       wr_known;
    assign woff     = bus_addr[11:2];
    assign wr_known = (woff == 10'd2) || (woff == 10'd3) || (woff == 10'd4) ||
                      (woff == 10'd5) || (woff == 10'd8) || (woff == 10'd9);

    p_level_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lvl == $past(irq_in));

    p_combined_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[31] == (|(lvl & msk)));

    p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && woff == 10'd2) |=> ((msk & $past(bus_wdata)) == $past(bus_wdata)));

    p_mask_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && woff == 10'd3) |=> ((msk & $past(bus_wdata)) == 32'd0));

    p_pt_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pt & 32'h801F_FFFF) == 32'd0);

    p_pt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && woff == 10'd9) |=> ((pt & $past(bus_wdata)) == 32'd0));

    p_idle_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & 32'h001F_FFFF) == 32'd0);

    p_unused_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_known) |=> ($stable(msk) && $stable(pt)));

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> (irq_out == 32'd0));

endmodule

bind sec_irq_ctrl sec_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .lvl       (lvl_w),
    .msk       (msk_w),
    .pt        (pt_w)
);

// File: tb/sec_irq_ctrl_test.sv
module sec_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_lvl = '0;
    logic [31:0] m_msk = '0;
    logic [31:0] m_pt  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_lines();
        return {|(m_lvl & m_msk), 31'd0} | (m_lvl & m_pt & 32'h7FE0_0000);
    endfunction

    task automatic set_irq(input logic [31:0] v);
        irq_in = v;
        @(negedge clk);
        m_lvl = v;
    endtask

    task automatic wr(input int off, input logic [31:0] d);
        bus_addr  = {off[9:0], 2'b00};
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        case (off)
            2: m_msk = m_msk | d;
            3: m_msk = m_msk & ~d;
            4: if (d != 0) m_msk[0] = 1'b1;
            5: if (d != 0) m_msk[0] = 1'b0;
            8: m_pt = m_pt | (d & 32'h7FE0_0000);
            9: m_pt = m_pt & ~d;
            default: ;
        endcase
    endtask

    task automatic rd(input int off, input logic [1:0] lo, input logic [31:0] exp, input string req);
        bus_addr = {off[9:0], lo};
        bus_rd   = 1'b1;
        #1;
        check(req, bus_rdata, exp);
        bus_rd   = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R10: state and outputs stay zero while reset holds, even with active sources
        irq_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R10 lines in reset", irq_out, 32'd0);
        rd(1, 2'b00, 32'd0, "R10 raw level in reset");
        irq_in = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 lines after reset", irq_out, 32'd0);
        rd(2, 2'b00, 32'd0, "R10 mask after reset");
        rd(8, 2'b00, 32'd0, "R10 passthrough after reset");

        // R1, R2, R3: walk one source while the mask grows bit by bit
        for (int i = 0; i < 32; i++) begin
            wr(2, 32'd1 << i);
            set_irq(32'd1 << i);
            check("R2 combined line", irq_out, exp_lines());
            rd(0, 2'b00, m_lvl & m_msk, "R3 status read");
            rd(1, 2'b00, m_lvl, "R1 raw level");
            set_irq(32'd0);
            check("R2 combined line idle", irq_out, exp_lines());
        end
        rd(2, 2'b00, 32'hFFFF_FFFF, "R3 mask read");
        bus_addr = 12'd4;
        #1;
        check("R3 rdata zero without strobe", bus_rdata, 32'd0);

        // R4: clear lower half of the mask, then test sources on both halves
        wr(3, 32'h0000_FFFF);
        rd(2, 2'b00, m_msk, "R4 mask clear");
        set_irq(32'h0000_0F00);
        check("R4 cleared sources do not request", irq_out, exp_lines());
        set_irq(32'h00F0_0000);
        check("R4 enabled sources request", irq_out, exp_lines());
        wr(3, 32'hFFFF_FFFF);
        check("R4 full clear drops request", irq_out, exp_lines());
        wr(2, 32'h0000_A5A5);
        rd(2, 2'b00, m_msk, "R4 mask set");
        wr(3, 32'hFFFF_FFFF);

        // R5: soft enable controls and soft read
        wr(4, 32'd0);
        rd(2, 2'b00, m_msk, "R5 zero soft set ignored");
        wr(4, 32'd5);
        rd(2, 2'b00, m_msk, "R5 soft set");
        set_irq(32'h0000_0001);
        rd(4, 2'b00, 32'd1, "R5 soft read level high");
        check("R5 soft source requests", irq_out, exp_lines());
        set_irq(32'hFFFF_FFFE);
        rd(4, 2'b00, 32'd0, "R5 soft read level low");
        wr(5, 32'd0);
        rd(2, 2'b00, m_msk, "R5 zero soft clear ignored");
        wr(5, 32'h8000_0000);
        rd(2, 2'b00, m_msk, "R5 soft clear");
        set_irq(32'd0);

        // R6, R8: passthrough enable with every bit written
        wr(8, 32'hFFFF_FFFF);
        rd(8, 2'b00, 32'h7FE0_0000, "R6 passthrough window");
        for (int i = 0; i < 32; i++) begin
            set_irq(32'd1 << i);
            check("R8 passthrough line", irq_out, exp_lines());
        end
        set_irq(32'hFFFF_FFFF);
        check("R8 all sources", irq_out, exp_lines());

        // R7: partial clear of the passthrough enable
        wr(9, 32'h0AA0_0000);
        rd(8, 2'b00, m_pt, "R7 passthrough clear");
        check("R7 cleared lines low", irq_out, exp_lines());
        wr(2, 32'h4000_0000);
        check("R8 line 31 stays combined", irq_out, exp_lines());

        // R9: every word offset, address low bits ignored
        rd(8, 2'b11, m_pt, "R9 byte lane ignored");
        for (int off = 0; off < 1024; off++) begin
            if (!(off == 2 || off == 3 || off == 4 || off == 5 || off == 8 || off == 9)) begin
                wr(off, 32'hFFFF_FFFF);
                rd(2, 2'b00, m_msk, "R9 mask after unused write");
                rd(8, 2'b00, m_pt, "R9 passthrough after unused write");
                check("R9 lines after unused write", irq_out, exp_lines());
            end
            if (!(off == 0 || off == 1 || off == 2 || off == 4 || off == 8))
                rd(off, 2'b00, 32'd0, "R9 unused read zero");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule